// File: doc/BRIEF.md
# Bus Fault Monitor

The monitor sits beside an on-chip interconnect and watches its traffic for two kinds of trouble. The first is a response that a slave returns with its error flag set. The second is a response that never arrives. For the second case it times one chosen master ID from the moment its command is accepted. If no response comes back within a programmable window, it declares a timeout.

The first fault of either kind freezes a record of the failing transaction. The record holds the 32-bit address and a 10-bit status word. The status word packs the cause, the command type and the master ID. Later faults are dropped until software erases the record by writing zero to it. An interrupt line stays high as long as any part of the record is held.

The observed interface carries one set of transaction fields. Those fields describe whatever is signalled in that cycle: a command acceptance (`obs_cmd_valid`), a response (`obs_rsp_valid`), or both. Software reaches three word registers through a simple write/read port with byte enables:

| Index | Contents |
|-------|----------|
| 0 | Captured address |
| 1 | Status word, bits [9:0] |
| 2 | Configuration: timed master ID in bits [3:0], timeout threshold in bits [12:8] |

Top module: `bus_fault_monitor`

## Requirements
- R1: After reset, register 0 and register 1 read 0, register 2 reads 0x0000_0800 (timed ID 0, threshold 8), and `irq` is low.
- R2: A response with `obs_rsp_err` high captures `obs_addr` into register 0. It also captures status {cause = `obs_port`+1 in [9:6], `obs_cmd` in [5:4], `obs_mid` in [3:0]} into register 1. Both are visible after that clock edge. Command code 2 means read and 1 means write.
- R3: Let L = threshold × 16 cycles. A read or write command accepted for the timed ID starts the timeout count. If no response for that ID is sampled on or before the (L+1)-th clock edge after the acceptance edge, that edge captures a timeout record. The record is the command's address, with status {cause 0, the command's code, the timed ID}.
- R4: A threshold of 0 disables timeout detection entirely.
- R5: Commands from master IDs other than the timed ID never start the timeout count.
- R6: While a register holds a capture, later error or timeout events leave it unchanged.
- R7: A write clears a register to zero, and releases its capture, when at least one enabled byte lane lies inside the register and every enabled lane carries zero. Register 0 uses lanes 0–3 and register 1 uses lanes 0–1. A single lane is enough.
- R8: A write whose enabled in-range lanes carry any nonzero byte, or whose enabled lanes all lie outside the register, leaves the register unchanged.
- R9: If a slave error response and a timeout fall in the same cycle, the error response is the one captured.
- R10: An event arriving in the same cycle as a clearing write to a held register is captured into that register.
- R11: A new accepted command for the timed ID restarts the count from zero. A response for that ID stops the count.
- R12: `irq` is high exactly while register 0 or register 1 holds a capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| obs_cmd_valid | input | 1 | A command is accepted this cycle |
| obs_rsp_valid | input | 1 | A response returns this cycle |
| obs_rsp_err | input | 1 | The returning response carries an error |
| obs_addr | input | 32 | Transaction address |
| obs_cmd | input | 2 | Command code: 2 read, 1 write |
| obs_mid | input | 4 | Master ID of the transaction |
| obs_port | input | 4 | Slave port index, 0 to 8 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_be | input | 4 | Byte-lane enables for the write |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | High while a capture is held |

## Verification
Two coincidences matter in this block. The first is a timeout expiring in the very cycle that another master's error response arrives. The bench provokes it by timing a command and placing an error response from a different ID exactly on the capture edge. It then requires that the status shows the slave-port cause rather than cause 0. The second is a clearing write landing in the same cycle as a new error. The bench requires the status to hold the new record, while the address register, which was not written, keeps the old one. The response deadline is also swept across several thresholds, with the response placed one edge before, at, and one edge after the last in-time edge.

// File: rtl/bfm_pkg.sv
package bfm_pkg;

  localparam logic [1:0] CMD_WRITE = 2'd1;
  localparam logic [1:0] CMD_READ  = 2'd2;

  // Threshold field to cycle count: thr scaled by 2**shift.
  function automatic int unsigned scaled_limit(input int unsigned thr, input int unsigned shift);
    return thr << shift;
  endfunction

  // A write clears when some enabled lane is inside the register (nb lanes)
  // and every such enabled lane is zero.
  function automatic logic lanes_clear(input logic [31:0] d, input logic [3:0] be,
                                       input int unsigned nb);
    logic any_lane;
    logic nonzero;
    any_lane = 1'b0;
    nonzero  = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (i < nb && be[i]) begin
        any_lane = 1'b1;
        if (d[8*i +: 8] != 8'h00) nonzero = 1'b1;
      end
    end
    return any_lane & ~nonzero;
  endfunction

endpackage

// File: rtl/bfm_timer.sv
module bfm_timer #(
  parameter int ADDR_W    = 32,
  parameter int MID_W     = 4,
  parameter int CMD_W     = 2,
  parameter int THR_W     = 5,
  parameter int THR_SHIFT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [THR_W-1:0]  thr,
  input  logic [MID_W-1:0]  sel,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [MID_W-1:0]  mid,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rsp_valid,
  output logic              tmo,
  output logic [ADDR_W-1:0] tmo_addr,
  output logic [CMD_W-1:0]  tmo_cmd
);
  import bfm_pkg::*;

  localparam int CNT_W = THR_W + THR_SHIFT;

  logic              busy;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  limit;
  logic [ADDR_W-1:0] addr_q;
  logic [CMD_W-1:0]  cmd_q;
  logic              accept;
  logic              rsp_hit;
  logic              armed;

  assign accept  = cmd_valid && (mid == sel) && (cmd != '0);
  assign rsp_hit = rsp_valid && (mid == sel);
  assign armed   = (thr != '0);
  assign limit   = CNT_W'(scaled_limit(32'(thr), THR_SHIFT));

  assign tmo      = busy && armed && (cnt >= limit) && !rsp_hit;
  assign tmo_addr = addr_q;
  assign tmo_cmd  = cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      addr_q <= '0;
      cmd_q  <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      cnt    <= '0;
      addr_q <= addr;
      cmd_q  <= cmd;
    end else if (rsp_hit || tmo) begin
      busy <= 1'b0;
    end else if (busy && cnt != '1) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R4: zero threshold never signals a timeout
  assert_no_tmo_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (thr == '0) |-> !tmo);

  // R3: a timeout ends the wait unless a new command restarts it
  assert_tmo_ends_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo && !accept) |=> !busy);

  // R11: acceptance restarts the count
  assert_restart_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && cnt == '0));

  // R11: a response for the timed ID stops the count
  assert_rsp_stops_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit && !accept) |=> !busy);

endmodule

// File: rtl/bfm_sticky.sv
module bfm_sticky #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt,
  input  logic [W-1:0] evt_data,
  input  logic         wr_hit,
  input  logic [31:0]  wr_data,
  input  logic [3:0]   wr_be,
  output logic [W-1:0] q,
  output logic         held
);
  import bfm_pkg::*;

  localparam int NB = (W + 7) / 8;

  logic clr;
  logic take;

  assign clr  = wr_hit && lanes_clear(wr_data, wr_be, NB);
  assign take = evt && (!held || clr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q    <= '0;
      held <= 1'b0;
    end else if (take) begin
      q    <= evt_data;
      held <= 1'b1;
    end else if (clr) begin
      q    <= '0;
      held <= 1'b0;
    end
  end

  // R6: a held capture stays put until cleared
  assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !clr) |=> (held && $stable(q)));

  // R7: zero write with no event empties the register
  assert_zero_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt) |=> (!held && q == '0));

  // R8: non-clearing write with no event changes nothing
  assert_nonzero_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !clr && !evt) |=> $stable(q));

  // R10: event coinciding with a clear is captured
  assert_clear_cycle_evt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && clr) |=> (held && q == $past(evt_data)));

endmodule

// File: rtl/bus_fault_monitor.sv
module bus_fault_monitor #(
  parameter int ADDR_W    = 32,
  parameter int MID_W     = 4,
  parameter int PORT_W    = 4,
  parameter int CMD_W     = 2,
  parameter int THR_W     = 5,
  parameter int THR_SHIFT = 4,
  parameter int THR_RESET = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              obs_cmd_valid,
  input  logic              obs_rsp_valid,
  input  logic              obs_rsp_err,
  input  logic [ADDR_W-1:0] obs_addr,
  input  logic [CMD_W-1:0]  obs_cmd,
  input  logic [MID_W-1:0]  obs_mid,
  input  logic [PORT_W-1:0] obs_port,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic [3:0]        reg_be,
  output logic [31:0]       reg_rdata,
  output logic              irq
);

  localparam int STA_W    = PORT_W + CMD_W + MID_W;
  localparam int THR_POS  = 8;

  logic [MID_W-1:0]  cfg_sel;
  logic [THR_W-1:0]  cfg_thr;

  logic              err_evt;
  logic              tmo;
  logic [ADDR_W-1:0] tmo_addr;
  logic [CMD_W-1:0]  tmo_cmd;
  logic              any_evt;
  logic [ADDR_W-1:0] evt_addr;
  logic [STA_W-1:0]  evt_sta;
  logic [ADDR_W-1:0] addr_q;
  logic [STA_W-1:0]  sta_q;
  logic              addr_held;
  logic              sta_held;

  // configuration register, byte-lane writes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_sel <= '0;
      cfg_thr <= THR_W'(THR_RESET);
    end else if (reg_wr && reg_addr == 2'd2) begin
      if (reg_be[0]) cfg_sel <= reg_wdata[MID_W-1:0];
      if (reg_be[1]) cfg_thr <= reg_wdata[THR_POS +: THR_W];
    end
  end

  bfm_timer #(
    .ADDR_W(ADDR_W), .MID_W(MID_W), .CMD_W(CMD_W),
    .THR_W(THR_W), .THR_SHIFT(THR_SHIFT)
  ) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .thr      (cfg_thr),
    .sel      (cfg_sel),
    .cmd_valid(obs_cmd_valid),
    .cmd      (obs_cmd),
    .mid      (obs_mid),
    .addr     (obs_addr),
    .rsp_valid(obs_rsp_valid),
    .tmo      (tmo),
    .tmo_addr (tmo_addr),
    .tmo_cmd  (tmo_cmd)
  );

  // error response outranks a coincident timeout
  assign err_evt  = obs_rsp_valid && obs_rsp_err;
  assign any_evt  = err_evt || tmo;
  assign evt_addr = err_evt ? obs_addr : tmo_addr;
  assign evt_sta  = err_evt ? {obs_port + PORT_W'(1), obs_cmd, obs_mid}
                            : {PORT_W'(0), tmo_cmd, cfg_sel};

  bfm_sticky #(.W(ADDR_W)) addr_cap_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (any_evt),
    .evt_data(evt_addr),
    .wr_hit  (reg_wr && reg_addr == 2'd0),
    .wr_data (reg_wdata),
    .wr_be   (reg_be),
    .q       (addr_q),
    .held    (addr_held)
  );

  bfm_sticky #(.W(STA_W)) sta_cap_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt     (any_evt),
    .evt_data(evt_sta),
    .wr_hit  (reg_wr && reg_addr == 2'd1),
    .wr_data (reg_wdata),
    .wr_be   (reg_be),
    .q       (sta_q),
    .held    (sta_held)
  );

  assign irq = addr_held || sta_held;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: reg_rdata[ADDR_W-1:0] = addr_q;
      2'd1: reg_rdata[STA_W-1:0]  = sta_q;
      2'd2: begin
        reg_rdata[MID_W-1:0]       = cfg_sel;
        reg_rdata[THR_POS +: THR_W] = cfg_thr;
      end
      default: reg_rdata = '0;
    endcase
  end

  // R12: the interrupt only rises after an event
  assert_irq_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(any_evt));

  // R9: an error response taken into an empty status register leaves a nonzero cause
  assert_err_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt && !sta_held) |=> (sta_q[STA_W-1 -: PORT_W] != '0));

  // R2: an error response taken into an empty address register records its address
  assert_err_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt && !addr_held) |=> (addr_q == $past(obs_addr)));

endmodule

// File: tb/bus_fault_monitor_tb_top.sv
module bus_fault_monitor_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        obs_cmd_valid = 1'b0;
  logic        obs_rsp_valid = 1'b0;
  logic        obs_rsp_err = 1'b0;
  logic [31:0] obs_addr = '0;
  logic [1:0]  obs_cmd = '0;
  logic [3:0]  obs_mid = '0;
  logic [3:0]  obs_port = '0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_fault_monitor dut_i (
    .clk(clk), .rst_n(rst_n),
    .obs_cmd_valid(obs_cmd_valid), .obs_rsp_valid(obs_rsp_valid),
    .obs_rsp_err(obs_rsp_err), .obs_addr(obs_addr), .obs_cmd(obs_cmd),
    .obs_mid(obs_mid), .obs_port(obs_port),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_be(reg_be), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] be);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
    cyc();
    reg_wr = 1'b0; reg_be = '0; reg_wdata = '0;
  endtask

  task automatic set_err(input logic [31:0] a, input logic [1:0] c, input logic [3:0] m,
                         input logic [3:0] p);
    obs_rsp_valid = 1'b1; obs_rsp_err = 1'b1;
    obs_addr = a; obs_cmd = c; obs_mid = m; obs_port = p;
  endtask

  task automatic idle_obs();
    obs_cmd_valid = 1'b0; obs_rsp_valid = 1'b0; obs_rsp_err = 1'b0;
  endtask

  task automatic err_rsp(input logic [31:0] a, input logic [1:0] c, input logic [3:0] m,
                         input logic [3:0] p);
    set_err(a, c, m, p);
    cyc();
    idle_obs();
  endtask

  task automatic accept(input logic [31:0] a, input logic [1:0] c, input logic [3:0] m);
    obs_cmd_valid = 1'b1; obs_addr = a; obs_cmd = c; obs_mid = m;
    cyc();
    idle_obs();
  endtask

  task automatic clear_all();
    wr(2'd0, 32'h0, 4'hF);
    wr(2'd1, 32'h0, 4'h3);
  endtask

  function automatic logic [31:0] sta(input int cause, input int c, input int m);
    return 32'((cause << 6) | (c << 4) | m);
  endfunction

  function automatic logic [31:0] cfg(input int thr, input int sel);
    return 32'((thr << 8) | sel);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] w;
    repeat (3) cyc();
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); check("R1 addr reset", v, 32'h0);
    rd(2'd1, v); check("R1 status reset", v, 32'h0);
    rd(2'd2, v); check("R1 config reset", v, 32'h0000_0800);
    check("R1 irq reset", {31'b0, irq}, 32'd0);

    // R2 error capture across every port
    for (int p = 0; p < 9; p++) begin
      int c;
      int m;
      c = (p % 2 == 1) ? 1 : 2;
      m = (p + 3) % 16;
      err_rsp(32'h1000_0000 + 32'(p) * 32'h100, 2'(c), 4'(m), 4'(p));
      check("R12 irq on error", {31'b0, irq}, 32'd1);
      rd(2'd1, v); check("R2 error status", v, sta(p + 1, c, m));
      rd(2'd0, v); check("R2 error addr", v, 32'h1000_0000 + 32'(p) * 32'h100);
      clear_all();
      check("R7 irq after clear", {31'b0, irq}, 32'd0);
    end

    // R3 / R11 deadline sweep: response one edge early, on the last in-time edge, one late
    for (int thr = 1; thr <= 3; thr++) begin
      int lim;
      int c;
      lim = thr * 16;
      c = (thr % 2 == 1) ? 2 : 1;
      wr(2'd2, cfg(thr, 6), 4'h3);
      for (int j = lim; j <= lim + 2; j++) begin
        bit expect_hit;
        expect_hit = (j > lim + 1);
        accept(32'h4000_0000 + 32'(j), 2'(c), 4'd6);
        for (int n = 1; n <= lim + 3; n++) begin
          if (n == j) begin
            obs_rsp_valid = 1'b1; obs_rsp_err = 1'b0; obs_mid = 4'd6;
          end
          cyc();
          idle_obs();
          if (n == lim) check("R3 no timeout before deadline", {31'b0, irq}, 32'd0);
        end
        check("R3 timeout vs response offset", {31'b0, irq}, {31'b0, expect_hit});
        if (expect_hit) begin
          rd(2'd1, v); check("R3 timeout status", v, sta(0, c, 6));
          rd(2'd0, v); check("R3 timeout addr", v, 32'h4000_0000 + 32'(j));
        end
        clear_all();
      end
    end

    // R4 zero threshold disables timeouts
    wr(2'd2, cfg(0, 6), 4'h3);
    accept(32'h5000_0000, 2'd2, 4'd6);
    repeat (520) cyc();
    check("R4 no timeout at thr 0", {31'b0, irq}, 32'd0);
    obs_rsp_valid = 1'b1; obs_mid = 4'd6; cyc(); idle_obs();

    // R5 only the selected ID is timed
    wr(2'd2, cfg(1, 6), 4'h3);
    accept(32'h5100_0000, 2'd1, 4'd2);
    repeat (40) cyc();
    check("R5 other master untimed", {31'b0, irq}, 32'd0);

    // R11 restart on a new command
    wr(2'd2, cfg(1, 3), 4'h3);
    accept(32'h6000_0000, 2'd1, 4'd3);
    repeat (9) cyc();
    accept(32'h6100_0000, 2'd2, 4'd3);
    repeat (16) cyc();
    check("R11 restarted count not expired", {31'b0, irq}, 32'd0);
    cyc();
    check("R11 timeout from restart", {31'b0, irq}, 32'd1);
    rd(2'd0, v); check("R11 restart addr", v, 32'h6100_0000);
    rd(2'd1, v); check("R11 restart status", v, sta(0, 2, 3));
    clear_all();

    // R9 error and timeout in the same cycle
    accept(32'h2222_0000, 2'd1, 4'd3);
    repeat (16) cyc();
    set_err(32'h3333_0000, 2'd2, 4'd5, 4'd2);
    cyc();
    idle_obs();
    rd(2'd1, v); check("R9 error wins status", v, sta(3, 2, 5));
    rd(2'd0, v); check("R9 error wins addr", v, 32'h3333_0000);
    clear_all();
    repeat (20) cyc();
    check("R9 timeout consumed", {31'b0, irq}, 32'd0);

    // R6 sticky first event
    err_rsp(32'hAAAA_0000, 2'd2, 4'd1, 4'd0);
    err_rsp(32'hBBBB_0000, 2'd1, 4'd2, 4'd4);
    rd(2'd0, v); check("R6 sticky addr", v, 32'hAAAA_0000);
    rd(2'd1, v); check("R6 sticky status", v, sta(1, 2, 1));

    // R8 non-clearing writes
    wr(2'd1, 32'h0000_0001, 4'h1);
    rd(2'd1, v); check("R8 nonzero status write", v, sta(1, 2, 1));
    wr(2'd0, 32'hFF00_0000, 4'h8);
    rd(2'd0, v); check("R8 nonzero addr write", v, 32'hAAAA_0000);
    wr(2'd1, 32'h0, 4'h4);
    rd(2'd1, v); check("R8 lane outside status", v, sta(1, 2, 1));

    // R7 single-lane clears, R12 irq follows
    wr(2'd0, 32'h0, 4'h4);
    rd(2'd0, v); check("R7 single lane clears addr", v, 32'h0);
    rd(2'd1, w); check("R7 status untouched", w, sta(1, 2, 1));
    check("R12 irq while status held", {31'b0, irq}, 32'd1);
    wr(2'd1, 32'hFFFF_00FF, 4'h2);
    rd(2'd1, v); check("R7 lane 1 clears status", v, 32'h0);
    check("R12 irq after both cleared", {31'b0, irq}, 32'd0);

    // R10 event in the clearing cycle
    err_rsp(32'hCCCC_0000, 2'd2, 4'd7, 4'd5);
    set_err(32'hDDDD_0000, 2'd1, 4'd9, 4'd8);
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h0; reg_be = 4'h3;
    cyc();
    idle_obs();
    reg_wr = 1'b0; reg_be = '0;
    rd(2'd1, v); check("R10 event captured on clear", v, sta(9, 1, 9));
    rd(2'd0, v); check("R10 addr kept old", v, 32'hCCCC_0000);
    clear_all();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule